// File: doc/BRIEF.md
# Programmable Multi-Modulus Divider Chain

This block divides a fast input clock by a ratio that may change from one output period to the next. It is built around the way a chain of 2/3 divide cells behaves. Three 4-bit control fields set how deep the chain is and whether its top cell is a 3/4 cell. That choice fixes a window of allowed ratios. The window starts at a power of two, or at one and a half times a power of two. Within it, the ratio is set by an integer offset plus a small signed correction from a delta-sigma modulator.

Once per output period the block emits a single-cycle period strobe. The ratio inputs are captured on that strobe and take effect for the next whole period. This lets the modulator feeding the block advance its state once per period. A divided clock, held high for the second half of each period, comes out alongside the strobe.

The ratio windows run from 32..63 at the shallowest plain setting to 384..639 at the deepest widened setting. A requested ratio outside the selected window is clamped to the nearest edge of that window.

Top module: `mmd_divider_chain`

## Requirements
- R1: After synchronous reset is released, the first clock cycle in which reset is seen low raises `period_strobe` and `div_clk`. The inputs present in that cycle set the length of the first period.
- R2: Chain depth k equals 3 minus the number of set bits in `stage_sel`, with a floor of 0 (four set bits also give k = 0). The base ratio is 32·2^k.
- R3: The window is widened when both `sel34[k]` and `bypass[k]` are 1. The lower bound then becomes 1.5 × base. A `sel34` bit at any other position, or one whose matching `bypass` bit is 0, has no effect.
- R4: The requested ratio is lower bound + `int_ofs` (unsigned) + `frac_delta` (4-bit two's complement).
- R5: A request above the window gives a period of lower bound + base − 1. Across all settings the period never exceeds 639.
- R6: A request below the lower bound gives a period equal to the lower bound.
- R7: The ratio inputs are captured only in a strobe cycle. A change made mid-period leaves the length of that period unchanged and applies from the following period.
- R8: `period_strobe` is high for exactly one cycle per period. Consecutive strobes are exactly R cycles apart, where R is the ratio captured at the earlier strobe.
- R9: In each period of ratio R, `div_clk` is high for the last floor(R/2) cycles, which include the strobe cycle, and low for the rest.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock |
| rst | input | 1 | Synchronous active-high reset |
| stage_sel | input | 4 | Active-cell mask; its population count sets chain depth |
| sel34 | input | 4 | Per-position 3/4 cell request |
| bypass | input | 4 | Per-position top-of-chain marker |
| int_ofs | input | 9 | Unsigned integer offset above the lower bound |
| frac_delta | input | 4 | Signed modulator correction, two's complement |
| div_clk | output | 1 | Divided clock, high in the second half of each period |
| period_strobe | output | 1 | One-cycle pulse marking the last cycle of each period |

## Verification
The bench walks every depth in both plain and widened form. For each setting it measures strobe spacing and `div_clk` high time for requests at the bottom and the top of the window, one clamped above, one clamped below, and one with a negative correction mid-window. A decoder that took the wrong bit position or ignored the 3/4 request would shift every period by a power-of-two step. A clamp with an off-by-one would give 1 cycle more or less at the window edges. Wrong sign extension of the correction would stretch the negative case by 16 cycles instead of shortening it. Separate cases change the inputs mid-period, place a stray `sel34` bit where it must be ignored, and use a full `stage_sel` mask. These catch a design that samples continuously or decodes depth loosely.

// File: rtl/mmd_pkg.sv
package mmd_pkg;

    localparam int MMD_STAGES   = 4;
    localparam int MMD_BASE_LOG = 5;
    localparam int MMD_OFS_W    = 9;
    localparam int MMD_DLT_W    = 4;

    localparam int MMD_RATIO_W  = MMD_BASE_LOG + MMD_STAGES + 1;
    localparam int MMD_SUM_W    = MMD_RATIO_W + 2;
    localparam int MMD_DEPTH_W  = $clog2(MMD_STAGES);
    localparam int MMD_CNT_W    = $clog2(MMD_STAGES + 1);

    typedef logic [MMD_RATIO_W-1:0] ratio_t;
    typedef logic [MMD_DEPTH_W-1:0] depth_t;

    typedef struct packed {
        depth_t depth;
        logic   widened;
        ratio_t lo;
        ratio_t hi;
    } range_t;

    localparam ratio_t MMD_MIN_RATIO = ratio_t'(1) << MMD_BASE_LOG;

    function automatic range_t range_bounds(input depth_t d, input logic wide);
        range_t r;
        ratio_t base;
        base      = ratio_t'(1) << (MMD_BASE_LOG + int'(d));
        r.depth   = d;
        r.widened = wide;
        r.lo      = wide ? (base + (base >> 1)) : base;
        r.hi      = r.lo + base - ratio_t'(1);
        return r;
    endfunction

    function automatic ratio_t clamp_ratio(input range_t r,
                                           input logic [MMD_OFS_W-1:0] ofs,
                                           input logic [MMD_DLT_W-1:0] dlt);
        logic signed [MMD_SUM_W-1:0] s_lo;
        logic signed [MMD_SUM_W-1:0] s_hi;
        logic signed [MMD_SUM_W-1:0] s_req;
        ratio_t res;
        s_lo  = $signed({{(MMD_SUM_W-MMD_RATIO_W){1'b0}}, r.lo});
        s_hi  = $signed({{(MMD_SUM_W-MMD_RATIO_W){1'b0}}, r.hi});
        s_req = s_lo
              + $signed({{(MMD_SUM_W-MMD_OFS_W){1'b0}}, ofs})
              + $signed({{(MMD_SUM_W-MMD_DLT_W){dlt[MMD_DLT_W-1]}}, dlt});
        if (s_req < s_lo)      res = r.lo;
        else if (s_req > s_hi) res = r.hi;
        else                   res = s_req[MMD_RATIO_W-1:0];
        return res;
    endfunction

endpackage

// File: rtl/mmd_cfg_decode.sv
module mmd_cfg_decode
    import mmd_pkg::*;
(
    input  logic [MMD_STAGES-1:0] stage_sel,
    input  logic [MMD_STAGES-1:0] sel34,
    input  logic [MMD_STAGES-1:0] bypass,
    output range_t                rng
);

    logic [MMD_CNT_W-1:0]  active_cnt;
    depth_t                depth;
    logic [MMD_STAGES-1:0] widen_hit;

    always_comb begin
        active_cnt = '0;
        for (int i = 0; i < MMD_STAGES; i++) begin
            active_cnt = active_cnt + MMD_CNT_W'(stage_sel[i]);
        end
    end

    always_comb begin
        if (active_cnt >= MMD_CNT_W'(MMD_STAGES - 1))
            depth = '0;
        else
            depth = depth_t'(MMD_CNT_W'(MMD_STAGES - 1) - active_cnt);
    end

    // A 3/4 cell takes effect only at the position that tops the chain.
    for (genvar g = 0; g < MMD_STAGES; g++) begin : g_widen
        assign widen_hit[g] = sel34[g] & bypass[g] & (depth == depth_t'(g));
    end

    assign rng = range_bounds(depth, |widen_hit);

endmodule

// File: rtl/mmd_ratio_sel.sv
module mmd_ratio_sel
    import mmd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 strobe,
    input  range_t               rng,
    input  logic [MMD_OFS_W-1:0] int_ofs,
    input  logic [MMD_DLT_W-1:0] frac_delta,
    output ratio_t               ratio_next,
    output ratio_t               ratio_q
);

    assign ratio_next = clamp_ratio(rng, int_ofs, frac_delta);

    always_ff @(posedge clk) begin
        if (rst)
            ratio_q <= MMD_MIN_RATIO;
        else if (strobe)
            ratio_q <= ratio_next;
    end

endmodule

// File: rtl/mmd_period_ctr.sv
module mmd_period_ctr
    import mmd_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  ratio_t load_ratio,
    input  ratio_t cur_ratio,
    output logic   strobe,
    output logic   div_clk
);

    ratio_t remain;

    assign strobe  = (remain == '0);
    assign div_clk = (remain < (cur_ratio >> 1));

    always_ff @(posedge clk) begin
        if (rst)
            remain <= '0;
        else if (strobe)
            remain <= load_ratio - ratio_t'(1);
        else
            remain <= remain - ratio_t'(1);
    end

endmodule

// File: rtl/mmd_divider_chain.sv
module mmd_divider_chain
    import mmd_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [MMD_STAGES-1:0] stage_sel,
    input  logic [MMD_STAGES-1:0] sel34,
    input  logic [MMD_STAGES-1:0] bypass,
    input  logic [MMD_OFS_W-1:0]  int_ofs,
    input  logic [MMD_DLT_W-1:0]  frac_delta,
    output logic                  div_clk,
    output logic                  period_strobe
);

    range_t rng;
    ratio_t ratio_next;
    ratio_t ratio_q;

    mmd_cfg_decode u_decode (
        .stage_sel (stage_sel),
        .sel34     (sel34),
        .bypass    (bypass),
        .rng       (rng)
    );

    mmd_ratio_sel u_ratio (
        .clk        (clk),
        .rst        (rst),
        .strobe     (period_strobe),
        .rng        (rng),
        .int_ofs    (int_ofs),
        .frac_delta (frac_delta),
        .ratio_next (ratio_next),
        .ratio_q    (ratio_q)
    );

    mmd_period_ctr u_ctr (
        .clk        (clk),
        .rst        (rst),
        .load_ratio (ratio_next),
        .cur_ratio  (ratio_q),
        .strobe     (period_strobe),
        .div_clk    (div_clk)
    );

endmodule

// File: rtl/mmd_divider_chkr.sv
module mmd_divider_chkr
    import mmd_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input logic   period_strobe,
    input logic   div_clk,
    input ratio_t ratio_q
);

    localparam ratio_t TOP_BASE  = ratio_t'(1) << (MMD_BASE_LOG + MMD_STAGES - 1);
    localparam ratio_t MAX_RATIO = TOP_BASE + (TOP_BASE >> 1) + TOP_BASE - ratio_t'(1);

    logic [MMD_RATIO_W:0] since_strobe;
    logic                 armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_strobe <= '0;
            armed        <= 1'b0;
        end else if (period_strobe) begin
            since_strobe <= (MMD_RATIO_W+1)'(1);
            armed        <= 1'b1;
        end else begin
            since_strobe <= since_strobe + (MMD_RATIO_W+1)'(1);
        end
    end

    p_period_len_r8: assert property (@(posedge clk) disable iff (rst)
        (period_strobe && armed) |-> (since_strobe == {1'b0, ratio_q}));

    p_single_strobe_r8: assert property (@(posedge clk) disable iff (rst)
        period_strobe |=> !period_strobe);

    p_ratio_in_range_r5: assert property (@(posedge clk) disable iff (rst)
        (ratio_q >= MMD_MIN_RATIO) && (ratio_q <= MAX_RATIO));

    p_hold_mid_period_r7: assert property (@(posedge clk) disable iff (rst)
        !period_strobe |=> $stable(ratio_q));

    p_high_at_strobe_r9: assert property (@(posedge clk) disable iff (rst)
        period_strobe |-> div_clk);

    p_low_after_strobe_r9: assert property (@(posedge clk) disable iff (rst)
        period_strobe |=> !div_clk);

endmodule

bind mmd_divider_chain mmd_divider_chkr u_chkr (
    .clk           (clk),
    .rst           (rst),
    .period_strobe (period_strobe),
    .div_clk       (div_clk),
    .ratio_q       (ratio_q)
);

// File: tb/mmd_divider_chain_test.sv
module mmd_divider_chain_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] stage_sel = 4'b1110;
    logic [3:0] sel34 = 4'b0000;
    logic [3:0] bypass = 4'b0001;
    logic [8:0] int_ofs = '0;
    logic [3:0] frac_delta = '0;
    logic       div_clk;
    logic       period_strobe;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #4 clk = ~clk;

    mmd_divider_chain uut (
        .clk           (clk),
        .rst           (rst),
        .stage_sel     (stage_sel),
        .sel34         (sel34),
        .bypass        (bypass),
        .int_ofs       (int_ofs),
        .frac_delta    (frac_delta),
        .div_clk       (div_clk),
        .period_strobe (period_strobe)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: got %0d cycles expected completion", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    task automatic check(input string tag, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    // Expected ratio computed from the requirement arithmetic (R2..R6).
    function automatic int exp_ratio(input int k, input bit wide, input int ofs, input int d);
        int base, lo, hi, req;
        base = 32 << k;
        lo   = wide ? base + base / 2 : base;
        hi   = lo + base - 1;
        req  = lo + ofs + d;
        if (req < lo) return lo;
        if (req > hi) return hi;
        return req;
    endfunction

    task automatic set_cfg(input int k, input bit wide);
        stage_sel = 4'((4'hF << (k + 1)) & 4'hF);
        bypass    = 4'(1 << k);
        sel34     = wide ? 4'(1 << k) : 4'b0000;
    endtask

    task automatic set_req(input int ofs, input int d);
        int_ofs    = 9'(ofs);
        frac_delta = 4'(d);
    endtask

    // Called at a negedge: wait for the capturing strobe, then measure one full period.
    task automatic measure(output int len, output int highs);
        while (!period_strobe) @(negedge clk);
        len = 0;
        highs = 0;
        do begin
            @(negedge clk);
            len++;
            highs += div_clk ? 1 : 0;
        end while (!period_strobe);
    endtask

    task automatic run_case(input string tag, input int exp);
        int len, highs;
        measure(len, highs);
        check({tag, " period"}, len, exp);
        check({tag, " R9 high cycles"}, highs, exp / 2);
    endtask

    initial begin
        int len, highs, old_r;

        // R1: reset state and first strobe
        set_cfg(0, 1'b0);
        set_req(5, 0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 strobe after reset", int'(period_strobe), 1);
        check("R1 div_clk after reset", int'(div_clk), 1);
        len = 0;
        do begin
            @(negedge clk);
            len++;
        end while (!period_strobe);
        check("R1 first period", len, 37);

        // Sweep all depths, plain and widened: R2, R3, R4, R5, R6, R8, R9
        for (int k = 0; k < 4; k++) begin
            for (int w = 0; w < 2; w++) begin
                int base;
                base = 32 << k;
                set_cfg(k, w[0]);
                set_req(0, 0);
                run_case($sformatf("R2 R3 R4 k%0d w%0d lower", k, w), exp_ratio(k, w[0], 0, 0));
                set_req(base - 1, 0);
                run_case($sformatf("R4 k%0d w%0d upper", k, w), exp_ratio(k, w[0], base - 1, 0));
                set_req(base - 1, 3);
                run_case($sformatf("R5 k%0d w%0d clamp high", k, w), exp_ratio(k, w[0], base - 1, 3));
                set_req(511, 7);
                run_case($sformatf("R5 k%0d w%0d clamp max", k, w), exp_ratio(k, w[0], 511, 7));
                set_req(0, -5);
                run_case($sformatf("R6 k%0d w%0d clamp low", k, w), exp_ratio(k, w[0], 0, -5));
                set_req(base / 2, -3);
                run_case($sformatf("R4 k%0d w%0d negative delta", k, w), exp_ratio(k, w[0], base / 2, -3));
            end
        end

        // R2: full stage_sel mask also selects depth 0
        stage_sel = 4'b1111; bypass = 4'b0001; sel34 = 4'b0000;
        set_req(10, 0);
        run_case("R2 full mask", 42);

        // R3: sel34 at a non-top position has no effect
        stage_sel = 4'b1110; bypass = 4'b0001; sel34 = 4'b0100;
        set_req(2, 0);
        run_case("R3 stray sel34", 34);

        // R3: sel34 at top position without matching bypass has no effect
        stage_sel = 4'b1100; bypass = 4'b0001; sel34 = 4'b0010;
        set_req(0, 0);
        run_case("R3 sel34 without bypass", 64);

        // R7: mid-period change does not alter the running period
        set_cfg(1, 1'b0);
        set_req(20, 0);
        measure(len, highs);
        old_r = 84;
        @(negedge clk);
        set_cfg(2, 1'b1);
        set_req(7, 1);
        len = 1;
        while (!period_strobe) begin
            @(negedge clk);
            len++;
        end
        check("R7 period after mid change", len, old_r);
        len = 0;
        highs = 0;
        do begin
            @(negedge clk);
            len++;
            highs += div_clk ? 1 : 0;
        end while (!period_strobe);
        check("R7 next period uses new ratio", len, 200);
        check("R8 R9 next period high cycles", highs, 100);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule